// File: doc/BRIEF.md
# Coprocessor Tightly Coupled Memory Window Registers

This block is the system-control coprocessor register file of a small processor core. The pipeline hands it move-to and move-from coprocessor requests as a raw instruction word, plus a write flag and write data. The block decodes four fields from that word: the coprocessor number, the primary register index (CRn), the secondary index (CRm) and the op2 selector.

It holds three state registers: one control register and two window registers. The window registers describe the placement of a data-side and an instruction-side tightly coupled memory. It also returns two fixed identification words.

From the stored registers the block derives an enable, base, size and end address for each memory window. The memory router uses these to steer loads, stores and fetches. A derived window is recomputed on every write to the control register or to that window's own register, and is held in flops until the next such write. Writes to cache-maintenance and protection register indices are accepted and have no effect.

Top module: `tcm_cp_regs`

## Requirements
- R1: Only requests whose coprocessor number field (instruction bits [11:8]) equals 15 are serviced. A read aimed at any other coprocessor returns zero, and a write to one changes no register or window output.
- R2: A read with CRn (bits [19:16]) = 0 returns 0x41059461 when op2 (bits [7:5]) is 0 and 0x0f0d2112 when op2 is 1.
- R3: The control register (CRn 1) resets to 0x00000078, reads back the value last written, and every write to it recomputes both windows.
- R4: When control bit 16 is set, the data window is enabled. Its base is the data window register with bits [11:0] cleared, and its size is 512 shifted left by bits [5:1] of that register.
- R5: When control bit 18 is set, the instruction window is enabled. Its size follows the same 512 << reg[5:1] rule, and its base is always 0 whatever the register holds.
- R6: An enabled window's end equals base plus size, modulo 2^32. A disabled window reports base 0xFFFFFFFF, size 0 and end 0, and both windows are disabled after reset.
- R7: Writes to CRn 2, 3, 5, 6 or 7 leave the control register, the window registers and all window outputs unchanged.
- R8: CRn 9 with CRm (bits [3:0]) = 1 selects the window registers: op2 0 is the data window register and op2 1 is the instruction window register. Each reads back what was last written, and each write recomputes its own window.
- R9: Reads of unimplemented locations return zero. These are CRn 0 with op2 of 2 or more, CRn 9 with any CRm/op2 pair other than the two in R8, and any CRn index not listed.
- R10: Read data appears combinationally in the cycle the request is presented and is zero when no read is requested. A write takes effect at the next rising edge, and derived window values change in the cycle after the write and not before.
- R11: The window size is truncated to 32 bits, so a shift exponent of 23 or more yields size 0, and exponent 22 yields 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A coprocessor request is presented this cycle |
| req_write | input | 1 | 1 = move to coprocessor (write), 0 = move from coprocessor (read) |
| req_insn | input | 32 | Instruction word carrying coprocessor number, CRn, CRm and op2 |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, combinational |
| data_win_en | output | 1 | Data window enabled |
| data_win_base | output | 32 | Data window base address |
| data_win_size | output | 32 | Data window size in bytes |
| data_win_end | output | 32 | Data window end address (base plus size) |
| inst_win_en | output | 1 | Instruction window enabled |
| inst_win_base | output | 32 | Instruction window base address |
| inst_win_size | output | 32 | Instruction window size in bytes |
| inst_win_end | output | 32 | Instruction window end address |

## Verification
The bench builds the block with its default parameters: coprocessor number 15, a 512-byte size unit, 4 KiB base alignment, and enable bits 16 and 18. With these values the bench can hand-compute the window sizes around the 32-bit truncation point. Exponent 22 yields the top bit alone, and the end address then wraps past 2^32 from a high base. Exponent 23 drives the size to zero. The default enable bit positions let a single control write switch each window on and off independently, so the bench can check that one window's outputs stay put while the other changes.

// File: rtl/tcm_cp_pkg.sv
package tcm_cp_pkg;

  localparam int XLEN = 32;

  typedef logic [XLEN-1:0] word_t;

  typedef struct packed {
    logic  en;
    word_t base;
    word_t size;
    word_t end_a;
  } region_t;

  localparam region_t REGION_OFF = '{en: 1'b0, base: '1, size: '0, end_a: '0};

  // Size of a window: one unit shifted by the 5-bit exponent field [5:1],
  // truncated to XLEN bits.
  function automatic word_t win_size(word_t r, int unsigned unit_log2);
    int unsigned sh;
    sh = unit_log2 + int'(r[5:1]);
    if (sh >= XLEN) return '0;
    return word_t'(1) << sh;
  endfunction

  // Base of a window: register with low alignment bits cleared, or zero.
  function automatic word_t win_base(word_t r, bit pin_zero, int unsigned align_log2);
    word_t mask;
    if (pin_zero) return '0;
    mask = '1;
    mask = mask << align_log2;
    return r & mask;
  endfunction

  function automatic region_t win_eval(word_t ctrl, word_t r, int unsigned en_bit,
                                       bit pin_zero, int unsigned unit_log2,
                                       int unsigned align_log2);
    region_t o;
    if (!ctrl[en_bit]) return REGION_OFF;
    o.en    = 1'b1;
    o.base  = win_base(r, pin_zero, align_log2);
    o.size  = win_size(r, unit_log2);
    o.end_a = o.base + o.size;
    return o;
  endfunction

endpackage

// File: rtl/tcm_cp_decode.sv
module tcm_cp_decode
  import tcm_cp_pkg::*;
#(
  parameter int CP_NUM = 15
) (
  input  logic        req_valid,
  input  logic        req_write,
  input  word_t       insn,
  output logic        wr_fire,
  output logic        rd_fire,
  output logic [3:0]  crn,
  output logic [3:0]  crm,
  output logic [2:0]  op2
);

  logic cp_hit;

  always_comb begin
    crn     = insn[19:16];
    crm     = insn[3:0];
    op2     = insn[7:5];
    cp_hit  = (insn[11:8] == 4'(CP_NUM));
    wr_fire = req_valid &  req_write & cp_hit;
    rd_fire = req_valid & ~req_write & cp_hit;
  end

endmodule

// File: rtl/tcm_region_calc.sv
module tcm_region_calc
  import tcm_cp_pkg::*;
#(
  parameter int unsigned EN_BIT     = 16,
  parameter bit          PIN_ZERO   = 1'b0,
  parameter int unsigned UNIT_LOG2  = 9,
  parameter int unsigned ALIGN_LOG2 = 12
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    upd,
  input  word_t   ctrl_nx,
  input  word_t   win_nx,
  output region_t win_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      win_o <= REGION_OFF;
    else if (upd)
      win_o <= win_eval(ctrl_nx, win_nx, EN_BIT, PIN_ZERO, UNIT_LOG2, ALIGN_LOG2);
  end

endmodule

// File: rtl/tcm_cp_regs.sv
module tcm_cp_regs
  import tcm_cp_pkg::*;
#(
  parameter int          CP_NUM       = 15,
  parameter logic [31:0] CTRL_RST     = 32'h0000_0078,
  parameter logic [31:0] ID_MAIN      = 32'h4105_9461,
  parameter logic [31:0] ID_CACHE     = 32'h0f0d_2112,
  parameter int unsigned DATA_EN_BIT  = 16,
  parameter int unsigned INST_EN_BIT  = 18,
  parameter int unsigned UNIT_LOG2    = 9,
  parameter int unsigned ALIGN_LOG2   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_insn,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        data_win_en,
  output logic [31:0] data_win_base,
  output logic [31:0] data_win_size,
  output logic [31:0] data_win_end,
  output logic        inst_win_en,
  output logic [31:0] inst_win_base,
  output logic [31:0] inst_win_size,
  output logic [31:0] inst_win_end
);

  localparam int NWIN = 2;  // index 0 = data window, 1 = instruction window
  localparam int unsigned EN_BITS [NWIN] = '{DATA_EN_BIT, INST_EN_BIT};
  localparam bit          PINNED  [NWIN] = '{1'b0, 1'b1};

  logic       wr_fire, rd_fire;
  logic [3:0] crn, crm;
  logic [2:0] op2;

  tcm_cp_decode #(.CP_NUM(CP_NUM)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .insn      (req_insn),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .crn       (crn),
    .crm       (crm),
    .op2       (op2)
  );

  // Named select events
  logic            sel_ctrl;
  logic [NWIN-1:0] sel_win;
  logic            ctrl_wr;
  word_t           ctrl_q, ctrl_nx;
  word_t           win_q  [NWIN];
  word_t           win_nx [NWIN];
  logic [NWIN-1:0] win_upd;
  region_t         win_r  [NWIN];

  always_comb begin
    sel_ctrl = (crn == 4'd1);
    for (int k = 0; k < NWIN; k++)
      sel_win[k] = (crn == 4'd9) && (crm == 4'd1) && (op2 == 3'(k));
    ctrl_wr = wr_fire & sel_ctrl;
    ctrl_nx = ctrl_wr ? req_wdata : ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= CTRL_RST;
    else if (ctrl_wr)
      ctrl_q <= req_wdata;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic own_wr;
    assign own_wr     = wr_fire & sel_win[g];
    assign win_nx[g]  = own_wr ? req_wdata : win_q[g];
    assign win_upd[g] = own_wr | ctrl_wr;

    always_ff @(posedge clk) begin
      if (!rst_n)
        win_q[g] <= '0;
      else if (own_wr)
        win_q[g] <= req_wdata;
    end

    tcm_region_calc #(
      .EN_BIT     (EN_BITS[g]),
      .PIN_ZERO   (PINNED[g]),
      .UNIT_LOG2  (UNIT_LOG2),
      .ALIGN_LOG2 (ALIGN_LOG2)
    ) u_calc (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (win_upd[g]),
      .ctrl_nx (ctrl_nx),
      .win_nx  (win_nx[g]),
      .win_o   (win_r[g])
    );
  end

  // Read mux
  always_comb begin
    rsp_rdata = '0;
    if (rd_fire) begin
      unique case (crn)
        4'd0: begin
          if (op2 == 3'd0)      rsp_rdata = ID_MAIN;
          else if (op2 == 3'd1) rsp_rdata = ID_CACHE;
        end
        4'd1: rsp_rdata = ctrl_q;
        4'd9: begin
          for (int k = 0; k < NWIN; k++)
            if (sel_win[k]) rsp_rdata = win_q[k];
        end
        default: rsp_rdata = '0;
      endcase
    end
  end

  assign data_win_en   = win_r[0].en;
  assign data_win_base = win_r[0].base;
  assign data_win_size = win_r[0].size;
  assign data_win_end  = win_r[0].end_a;
  assign inst_win_en   = win_r[1].en;
  assign inst_win_base = win_r[1].base;
  assign inst_win_size = win_r[1].size;
  assign inst_win_end  = win_r[1].end_a;

endmodule

// File: rtl/tcm_cp_regs_chk.sv
module tcm_cp_regs_chk #(
  parameter int CP_NUM = 15
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [31:0] req_insn,
  input logic [31:0] req_wdata,
  input logic [31:0] rsp_rdata,
  input logic [31:0] ctrl_q,
  input logic        data_win_en,
  input logic [31:0] data_win_base,
  input logic [31:0] data_win_size,
  input logic [31:0] data_win_end,
  input logic        inst_win_en,
  input logic [31:0] inst_win_base,
  input logic [31:0] inst_win_size,
  input logic [31:0] inst_win_end
);

  logic foreign, own_cp, crn_ignored, crn_ctrl;
  always_comb begin
    own_cp      = (req_insn[11:8] == 4'(CP_NUM));
    foreign     = req_valid && !own_cp;
    crn_ctrl    = (req_insn[19:16] == 4'd1);
    crn_ignored = (req_insn[19:16] inside {4'd2, 4'd3, 4'd5, 4'd6, 4'd7});
  end

  p_foreign_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    foreign && !req_write |-> rsp_rdata == 32'd0);

  p_foreign_write_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    foreign && req_write |=> $stable(ctrl_q) && $stable(data_win_base)
                          && $stable(data_win_size) && $stable(inst_win_size));

  p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && own_cp && crn_ctrl |=> ctrl_q == $past(req_wdata));

  p_data_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_win_en |-> data_win_base[11:0] == 12'd0);

  p_inst_base_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inst_win_en |-> inst_win_base == 32'd0);

  p_data_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !data_win_en |-> data_win_base == 32'hFFFF_FFFF && data_win_size == 32'd0
                     && data_win_end == 32'd0);

  p_inst_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_win_en |-> inst_win_base == 32'hFFFF_FFFF && inst_win_size == 32'd0
                     && inst_win_end == 32'd0);

  p_ignored_crn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && own_cp && crn_ignored |=>
      $stable(ctrl_q) && $stable(data_win_en) && $stable(data_win_end)
      && $stable(inst_win_en) && $stable(inst_win_end));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> rsp_rdata == 32'd0);

  p_size_pow2_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(data_win_size) <= 1 && $countones(inst_win_size) <= 1);

endmodule

bind tcm_cp_regs tcm_cp_regs_chk #(.CP_NUM(CP_NUM)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_insn      (req_insn),
  .req_wdata     (req_wdata),
  .rsp_rdata     (rsp_rdata),
  .ctrl_q        (ctrl_q),
  .data_win_en   (data_win_en),
  .data_win_base (data_win_base),
  .data_win_size (data_win_size),
  .data_win_end  (data_win_end),
  .inst_win_en   (inst_win_en),
  .inst_win_base (inst_win_base),
  .inst_win_size (inst_win_size),
  .inst_win_end  (inst_win_end)
);

// File: tb/sim_tcm_cp_regs.sv
`timescale 1ns/1ps
module sim_tcm_cp_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_insn = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        data_win_en, inst_win_en;
  logic [31:0] data_win_base, data_win_size, data_win_end;
  logic [31:0] inst_win_base, inst_win_size, inst_win_end;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  tcm_cp_regs u0 (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write),
    .req_insn (req_insn), .req_wdata (req_wdata), .rsp_rdata (rsp_rdata),
    .data_win_en (data_win_en), .data_win_base (data_win_base),
    .data_win_size (data_win_size), .data_win_end (data_win_end),
    .inst_win_en (inst_win_en), .inst_win_base (inst_win_base),
    .inst_win_size (inst_win_size), .inst_win_end (inst_win_end)
  );

  // Instruction word: CRn [19:16], coprocessor [11:8], op2 [7:5], CRm [3:0]
  function automatic logic [31:0] mk(int cp, int crn, int op2, int crm);
    return (32'(crn) << 16) | (32'(cp) << 8) | (32'(op2) << 5) | 32'(crm);
  endfunction

  // Independent restatement of the window rules
  function automatic logic [31:0] exp_size(logic [31:0] r);
    int e;
    e = 9 + int'((r >> 1) & 32'h1F);
    return (e > 31) ? 32'd0 : (32'd1 << e);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] insn, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_insn = insn; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  task automatic do_read(string tag, logic [31:0] insn, logic [31:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_insn = insn;
    #1 chk(tag, rsp_rdata, exp);
    req_valid = 1'b0;
  endtask

  task automatic chk_win(string tag, logic is_inst, logic en,
                         logic [31:0] b, logic [31:0] s, logic [31:0] e);
    if (is_inst) begin
      chk({tag, " inst en"},   32'(inst_win_en), 32'(en));
      chk({tag, " inst base"}, inst_win_base, b);
      chk({tag, " inst size"}, inst_win_size, s);
      chk({tag, " inst end"},  inst_win_end, e);
    end else begin
      chk({tag, " data en"},   32'(data_win_en), 32'(en));
      chk({tag, " data base"}, data_win_base, b);
      chk({tag, " data size"}, data_win_size, s);
      chk({tag, " data end"},  data_win_end, e);
    end
  endtask

  // Vector: {write, req index, insn, wdata, expected read}
  localparam int NV = 16;
  localparam logic [100:0] VEC [NV] = '{
    {1'b0, 4'd3,  32'h0001_0F00, 32'h0,          32'h0000_0078}, // R3 reset value
    {1'b0, 4'd2,  32'h0000_0F00, 32'h0,          32'h4105_9461}, // R2 main id
    {1'b0, 4'd2,  32'h0000_0F20, 32'h0,          32'h0f0d_2112}, // R2 cache id
    {1'b0, 4'd9,  32'h0000_0F40, 32'h0,          32'h0},         // R9 crn0 op2=2
    {1'b1, 4'd8,  32'h0009_0F01, 32'h0080_000A, 32'h0},         // R8 data reg
    {1'b0, 4'd8,  32'h0009_0F01, 32'h0,          32'h0080_000A},
    {1'b1, 4'd8,  32'h0009_0F21, 32'h0000_0010, 32'h0},         // R8 inst reg
    {1'b0, 4'd8,  32'h0009_0F21, 32'h0,          32'h0000_0010},
    {1'b1, 4'd1,  32'h0001_0E00, 32'h0005_FFFF, 32'h0},         // R1 foreign write
    {1'b0, 4'd1,  32'h0001_0F00, 32'h0,          32'h0000_0078},
    {1'b0, 4'd1,  32'h0000_0E00, 32'h0,          32'h0},         // R1 foreign read
    {1'b1, 4'd7,  32'h0002_0F00, 32'hFFFF_FFFF, 32'h0},         // R7 crn2
    {1'b1, 4'd7,  32'h0007_0F00, 32'hFFFF_FFFF, 32'h0},         // R7 crn7
    {1'b0, 4'd7,  32'h0001_0F00, 32'h0,          32'h0000_0078},
    {1'b0, 4'd9,  32'h0009_0F02, 32'h0,          32'h0},         // R9 crn9 crm2
    {1'b0, 4'd9,  32'h0004_0F00, 32'h0,          32'h0}          // R9 crn4
  };

  initial begin
    #800000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: both windows disabled after reset
    chk_win("R6 reset", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd0, 32'd0);
    chk_win("R6 reset", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'd0, 32'd0);
    // R10: no request gives zero data
    #1 chk("R10 idle rdata", rsp_rdata, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][100]) do_write(VEC[i][95:64], VEC[i][63:32]);
      else do_read($sformatf("R%0d vec%0d", VEC[i][99:96], i), VEC[i][95:64], VEC[i][31:0]);
    end
    // R7: window registers survived ignored writes
    do_read("R7 data reg kept", mk(15, 9, 0, 1), 32'h0080_000A);

    // R10: outputs stay until the edge, change after it
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_insn = mk(15, 1, 0, 0);
    req_wdata = 32'h0005_0078;
    #1 chk("R10 before edge", 32'(data_win_en), 32'd0);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    // R3 R4 R5: both enabled
    do_read("R3 ctrl readback", mk(15, 1, 0, 0), 32'h0005_0078);
    chk_win("R4", 1'b0, 1'b1, 32'h0080_0000, exp_size(32'h0080_000A), 32'h0080_4000);
    chk_win("R5", 1'b1, 1'b1, 32'h0, exp_size(32'h10), 32'h0002_0000);

    // R5: high bits in instruction reg never move the base
    do_write(mk(15, 9, 1, 1), 32'hABCD_E004);
    chk_win("R5 pinned", 1'b1, 1'b1, 32'h0, 32'h0000_0800, 32'h0000_0800);

    // R6: switch off instruction window only
    do_write(mk(15, 1, 0, 0), 32'h0001_0078);
    chk_win("R6 off", 1'b1, 1'b0, 32'hFFFF_FFFF, 32'd0, 32'd0);
    chk_win("R6 other kept", 1'b0, 1'b1, 32'h0080_0000, 32'h0000_4000, 32'h0080_4000);

    // R7: ignored crn leaves windows
    do_write(mk(15, 3, 0, 0), 32'h0);
    do_write(mk(15, 6, 0, 0), 32'h0);
    chk_win("R7 windows kept", 1'b0, 1'b1, 32'h0080_0000, 32'h0000_4000, 32'h0080_4000);

    // R11 + R6: exponent 22 gives top bit, end wraps
    do_write(mk(15, 9, 0, 1), 32'hFFFF_F02C);
    chk_win("R11 exp22", 1'b0, 1'b1, 32'hFFFF_F000, 32'h8000_0000, 32'h7FFF_F000);
    // R11: exponent 23 yields zero size
    do_write(mk(15, 9, 0, 1), 32'h0000_302E);
    chk_win("R11 exp23", 1'b0, 1'b1, 32'h0000_3000, 32'd0, 32'h0000_3000);

    // R4: clearing bit 16 disables data window
    do_write(mk(15, 1, 0, 0), 32'h0000_0078);
    chk_win("R4 off", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd0, 32'd0);

    // R3: reset restores control value
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_read("R3 after reset", mk(15, 1, 0, 0), 32'h0000_0078);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule